// File: doc/BRIEF.md
# One-Wire MAC Address Fetch Sequencer

This block fetches a 48-bit Ethernet station address from a serial memory on a one-wire bus. It runs the whole transaction: a bus reset with presence sensing, a fixed four-byte command header, one header-check byte, and a fixed-length data record. It then validates the record against a 16-character ASCII tag and builds the address. The block never touches the wire. A slot engine below it handles line timing and bit slots. The sequencer hands that engine one operation at a time (bus reset, byte write or byte read) with a one-cycle request and waits for its one-cycle completion.

The address always starts with a fixed 24-bit vendor prefix. When the tag matches, the low three bytes come from record bytes 7, 6 and 5, in that order, so the record's little-endian serial field is reversed. When the tag does not match, or no device answers, the low three bytes are all ones and an error code says why. The result holds until the next start. A single-cycle done pulse marks that it is ready.

Top module: `mac_fetch_seq`

## Requirements
- R1: After reset, `busy`, `done` and `eng_start` are 0, `err_code` is 0 and `mac_addr` is 0.
- R2: A start issues a bus-reset operation first (`eng_op` 0). If `eng_present` is 0 when it completes, no further operation is issued and `err_code` becomes 1.
- R3: After presence, four write operations (`eng_op` 1) carry the bytes 0xCC, 0xF0, 0x00, 0x00 in that order on `eng_wdata`.
- R4: One read operation (`eng_op` 2) follows the header. Its byte appears on `crc_byte` and has no effect on `mac_addr` or `err_code`.
- R5: Exactly REC_LEN (28) further reads follow, stored as record bytes 0 to 27 in arrival order. A transaction issues 34 operations in total.
- R6: When record bytes 11 to 26 equal the 16 characters of SIG_TEXT (first character at byte 11), `err_code` is 0 and `mac_addr` is {0x00, 0xE0, 0xEE, rec[7], rec[6], rec[5]}, most significant byte first. Bytes outside 11 to 26 do not affect the match.
- R7: Any single mismatching byte in the tag sets `err_code` to 2 and `mac_addr` to 0x00E0EEFFFFFF.
- R8: In the no-device case, `mac_addr` is also 0x00E0EEFFFFFF.
- R9: `done` is high for exactly one cycle per transaction, in the same cycle that `busy` drops and the new `mac_addr`/`err_code` first appear.
- R10: `mac_addr`, `err_code` and `crc_byte` hold while idle. A start while `busy` is ignored.
- R11: Each engine request `eng_start` is a single-cycle pulse. No new request is made until the previous one has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fetch (ignored while busy) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle result-ready pulse |
| mac_addr | output | 48 | Assembled station address |
| err_code | output | 2 | 0 ok, 1 no device, 2 bad tag |
| crc_byte | output | 8 | Header-check byte returned by the device |
| eng_start | output | 1 | One-cycle request to the slot engine |
| eng_op | output | 2 | 0 bus reset, 1 write byte, 2 read byte |
| eng_wdata | output | 8 | Byte to write |
| eng_done | input | 1 | One-cycle completion from the slot engine |
| eng_rdata | input | 8 | Byte read, valid with eng_done |
| eng_present | input | 1 | Presence result, valid with eng_done after a bus reset |

## Verification
The bench places a behavioural slot engine under the block and sweeps engine latency, record contents and the position of a corrupted tag byte across all 16 tag offsets. An off-by-one tag window or reversed character order would accept a corrupted byte at one end, or reject a clean record. Taking the serial bytes in forward order, or from a shifted index, shows up as a wrong low address word. The header-check byte is varied between runs with the record fixed, so a design that folded it into the result would change its output. A start fired mid-transaction, and a count of engine operations in each run, catch restart or extra-read bugs. Idle cycles after done catch outputs that do not hold.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_EVAL  = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        STEP_RESET = 2'd0,
        STEP_CMD   = 2'd1,
        STEP_CRC   = 2'd2,
        STEP_DATA  = 2'd3
    } step_e;

    localparam logic [1:0] ERR_OK    = 2'd0;
    localparam logic [1:0] ERR_NODEV = 2'd1;
    localparam logic [1:0] ERR_BADSIG = 2'd2;
endpackage

// File: rtl/mfs_record.sv
module mfs_record #(
    parameter int REC_LEN = 28,
    parameter int IDX_W   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [7:0]             wbyte,
    output logic [REC_LEN*8-1:0]   rec
);
    logic [REC_LEN*8-1:0] rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (we) begin
            rec_d[8*int'(idx) +: 8] = wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign rec = rec_q;

    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(idx) < REC_LEN));
endmodule

// File: rtl/mfs_sigcheck.sv
module mfs_sigcheck #(
    parameter int                    REC_LEN  = 28,
    parameter int                    SIG_OFF  = 11,
    parameter int                    SIG_LEN  = 16,
    parameter logic [SIG_LEN*8-1:0]  SIG_TEXT = "OUI-TAG 802.3 ID",
    parameter int                    SER_IDX  = 5,
    parameter logic [23:0]           OUI      = 24'h00E0EE
) (
    input  logic [REC_LEN*8-1:0] rec,
    output logic                 sig_ok,
    output logic [47:0]          mac_good
);
    logic [SIG_LEN-1:0] hit;

    for (genvar k = 0; k < SIG_LEN; k++) begin : g_cmp
        assign hit[k] = (rec[8*(SIG_OFF+k) +: 8] == SIG_TEXT[8*(SIG_LEN-1-k) +: 8]);
    end

    assign sig_ok   = &hit;
    assign mac_good = {OUI,
                       rec[8*(SER_IDX+2) +: 8],
                       rec[8*(SER_IDX+1) +: 8],
                       rec[8*SER_IDX +: 8]};
endmodule

// File: rtl/mfs_ctrl.sv
module mfs_ctrl
    import mfs_pkg::*;
#(
    parameter int          REC_LEN = 28,
    parameter int          IDX_W   = 5,
    parameter int          N_CMD   = 4,
    parameter logic [N_CMD*8-1:0] CMD_SEQ = 32'hCCF0_0000,
    parameter logic [23:0] OUI     = 24'h00E0EE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             eng_done,
    input  logic [7:0]       eng_rdata,
    input  logic             eng_present,
    input  logic             sig_ok,
    input  logic [47:0]      mac_good,
    output logic             busy,
    output logic             done,
    output logic [47:0]      mac_addr,
    output logic [1:0]       err_code,
    output logic [7:0]       crc_byte,
    output logic             eng_start,
    output logic [1:0]       eng_op,
    output logic [7:0]       eng_wdata,
    output logic             rec_we,
    output logic [IDX_W-1:0] rec_idx
);
    localparam logic [47:0] FALLBACK = {OUI, 24'hFFFFFF};
    localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(N_CMD - 1);
    localparam logic [IDX_W-1:0] REC_LAST = IDX_W'(REC_LEN - 1);

    typedef struct packed {
        state_e           state;
        step_e            step;
        logic [IDX_W-1:0] idx;
        logic             busy;
        logic             done;
        logic [47:0]      mac;
        logic [1:0]       err;
        logic [7:0]       crc;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_ISSUE;
                    d.step  = STEP_RESET;
                    d.idx   = '0;
                    d.busy  = 1'b1;
                end
            end
            ST_ISSUE: d.state = ST_WAIT;
            ST_WAIT: begin
                if (eng_done) begin
                    unique case (q.step)
                        STEP_RESET: begin
                            if (!eng_present) begin
                                d.mac   = FALLBACK;
                                d.err   = ERR_NODEV;
                                d.done  = 1'b1;
                                d.busy  = 1'b0;
                                d.state = ST_IDLE;
                            end else begin
                                d.step  = STEP_CMD;
                                d.idx   = '0;
                                d.state = ST_ISSUE;
                            end
                        end
                        STEP_CMD: begin
                            if (q.idx == CMD_LAST) begin
                                d.step = STEP_CRC;
                                d.idx  = '0;
                            end else begin
                                d.idx = q.idx + 1'b1;
                            end
                            d.state = ST_ISSUE;
                        end
                        STEP_CRC: begin
                            d.crc   = eng_rdata;
                            d.step  = STEP_DATA;
                            d.idx   = '0;
                            d.state = ST_ISSUE;
                        end
                        STEP_DATA: begin
                            if (q.idx == REC_LAST) begin
                                d.state = ST_EVAL;
                            end else begin
                                d.idx   = q.idx + 1'b1;
                                d.state = ST_ISSUE;
                            end
                        end
                        default: d.state = ST_IDLE;
                    endcase
                end
            end
            ST_EVAL: begin
                d.mac   = sig_ok ? mac_good : FALLBACK;
                d.err   = sig_ok ? ERR_OK : ERR_BADSIG;
                d.done  = 1'b1;
                d.busy  = 1'b0;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.step  <= STEP_RESET;
            q.idx   <= '0;
            q.busy  <= 1'b0;
            q.done  <= 1'b0;
            q.mac   <= '0;
            q.err   <= ERR_OK;
            q.crc   <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        eng_start = (q.state == ST_ISSUE);
        unique case (q.step)
            STEP_RESET: eng_op = OP_RESET;
            STEP_CMD:   eng_op = OP_WRITE;
            default:    eng_op = OP_READ;
        endcase
        eng_wdata = 8'h00;
        if (q.step == STEP_CMD) begin
            eng_wdata = CMD_SEQ[8*(N_CMD-1-int'(q.idx)) +: 8];
        end
        rec_we  = (q.state == ST_WAIT) && eng_done && (q.step == STEP_DATA);
        rec_idx = q.idx;
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign mac_addr = q.mac;
    assign err_code = q.err;
    assign crc_byte = q.crc;

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    a_r2_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (eng_start && eng_op == OP_RESET));
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(mac_addr) && $stable(err_code) && $stable(crc_byte)));
    a_r8_nodev_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == ERR_NODEV) |-> (mac_addr == FALLBACK));
    a_r7_err_legal: assert property (@(posedge clk) disable iff (!rst_n)
        err_code != 2'd3);
    a_r6_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mac_addr[47:24] == OUI));
endmodule

// File: rtl/mac_fetch_seq.sv
module mac_fetch_seq #(
    parameter int                   REC_LEN  = 28,
    parameter int                   SIG_OFF  = 11,
    parameter int                   SIG_LEN  = 16,
    parameter logic [SIG_LEN*8-1:0] SIG_TEXT = "OUI-TAG 802.3 ID",
    parameter int                   SER_IDX  = 5,
    parameter logic [23:0]          OUI      = 24'h00E0EE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic [47:0] mac_addr,
    output logic [1:0]  err_code,
    output logic [7:0]  crc_byte,
    output logic        eng_start,
    output logic [1:0]  eng_op,
    output logic [7:0]  eng_wdata,
    input  logic        eng_done,
    input  logic [7:0]  eng_rdata,
    input  logic        eng_present
);
    localparam int IDX_W = (REC_LEN > 4) ? $clog2(REC_LEN) : 2;

    logic [REC_LEN*8-1:0] rec;
    logic                 sig_ok;
    logic [47:0]          mac_good;
    logic                 rec_we;
    logic [IDX_W-1:0]     rec_idx;

    mfs_ctrl #(
        .REC_LEN (REC_LEN),
        .IDX_W   (IDX_W),
        .N_CMD   (4),
        .CMD_SEQ (32'hCCF0_0000),
        .OUI     (OUI)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .eng_done    (eng_done),
        .eng_rdata   (eng_rdata),
        .eng_present (eng_present),
        .sig_ok      (sig_ok),
        .mac_good    (mac_good),
        .busy        (busy),
        .done        (done),
        .mac_addr    (mac_addr),
        .err_code    (err_code),
        .crc_byte    (crc_byte),
        .eng_start   (eng_start),
        .eng_op      (eng_op),
        .eng_wdata   (eng_wdata),
        .rec_we      (rec_we),
        .rec_idx     (rec_idx)
    );

    mfs_record #(
        .REC_LEN (REC_LEN),
        .IDX_W   (IDX_W)
    ) rec_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rec_we),
        .idx   (rec_idx),
        .wbyte (eng_rdata),
        .rec   (rec)
    );

    mfs_sigcheck #(
        .REC_LEN  (REC_LEN),
        .SIG_OFF  (SIG_OFF),
        .SIG_LEN  (SIG_LEN),
        .SIG_TEXT (SIG_TEXT),
        .SER_IDX  (SER_IDX),
        .OUI      (OUI)
    ) sig_i (
        .rec      (rec),
        .sig_ok   (sig_ok),
        .mac_good (mac_good)
    );
endmodule

// File: tb/mac_fetch_seq_tb_top.sv
module mac_fetch_seq_tb_top;
    localparam logic [127:0] TAG = "OUI-TAG 802.3 ID";
    localparam logic [47:0]  FB  = 48'h00E0EE_FFFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, eng_start;
    logic [47:0] mac_addr;
    logic [1:0] err_code, eng_op;
    logic [7:0] crc_byte, eng_wdata;
    logic eng_done = 1'b0;
    logic [7:0] eng_rdata = 8'h00;
    logic eng_present = 1'b0;

    always #10 clk = ~clk;

    mac_fetch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .mac_addr(mac_addr), .err_code(err_code), .crc_byte(crc_byte),
        .eng_start(eng_start), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_done(eng_done), .eng_rdata(eng_rdata), .eng_present(eng_present)
    );

    // behavioural slot engine
    logic [7:0] rec_img [28];
    logic [7:0] crc_img;
    int         lat = 1;
    logic       dev_here = 1'b1;
    int         n_ops;
    int         n_rd;
    logic [1:0] op_log [40];
    logic [7:0] wd_log [40];
    logic       pend = 1'b0;
    int         cnt = 0;
    logic [7:0] pend_data = 8'h00;
    logic       overlap_err = 1'b0;

    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                eng_done  <= 1'b1;
                eng_rdata <= pend_data;
                pend      <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (eng_start) begin
            if (pend) overlap_err <= 1'b1;
            pend <= 1'b1;
            cnt  <= lat;
            if (n_ops < 40) begin
                op_log[n_ops] = eng_op;
                wd_log[n_ops] = eng_wdata;
            end
            n_ops = n_ops + 1;
            if (eng_op == 2'd0) eng_present <= dev_here;
            if (eng_op == 2'd2) begin
                pend_data <= (n_rd == 0) ? crc_img : rec_img[(n_rd - 1) % 28];
                n_rd = n_rd + 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill(input int seed, input int bad_pos);
        for (int i = 0; i < 28; i++) rec_img[i] = 8'((seed * 37 + i * 11 + 5) & 8'hFF);
        for (int k = 0; k < 16; k++) rec_img[11 + k] = TAG[8*(15-k) +: 8];
        if (bad_pos >= 0) rec_img[11 + bad_pos] = rec_img[11 + bad_pos] ^ 8'h20;
    endtask

    // run one transaction; returns after done has been seen
    task automatic run(input bit poke_busy);
        int waited;
        bit seen;
        n_ops = 0;
        n_rd  = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        waited = 0;
        while (!seen && waited < 3000) begin
            if (poke_busy && waited == 9) start = 1'b1;
            else start = 1'b0;
            if (done) seen = 1'b1;
            else begin
                @(negedge clk);
                waited++;
            end
        end
        start = 1'b0;
        chk(seen, "R9 done seen", 64'(seen), 64'd1);
        @(negedge clk);
        chk(!done, "R9 done single cycle", 64'(done), 64'd0);
        chk(!busy, "R9 busy low after done", 64'(busy), 64'd0);
    endtask

    task automatic chk_log(input int exp_ops);
        chk(n_ops == exp_ops, "R5 operation count", 64'(n_ops), 64'(exp_ops));
        chk(op_log[0] == 2'd0, "R2 first op is bus reset", 64'(op_log[0]), 64'd0);
        if (exp_ops > 1) begin
            for (int i = 1; i <= 4; i++) begin
                logic [7:0] e;
                e = (i == 1) ? 8'hCC : (i == 2) ? 8'hF0 : 8'h00;
                chk(op_log[i] == 2'd1 && wd_log[i] == e, "R3 header byte",
                    64'({op_log[i], wd_log[i]}), 64'({2'd1, e}));
            end
            for (int i = 5; i < 34; i++)
                chk(op_log[i] == 2'd2, "R4 R5 read op", 64'(op_log[i]), 64'd2);
        end
        chk(!overlap_err, "R11 request while pending", 64'(overlap_err), 64'd0);
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !eng_start, "R1 idle flags", 64'({busy, done, eng_start}), 64'd0);
        chk(err_code == 2'd0 && mac_addr == 48'd0, "R1 outputs zero", 64'(mac_addr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R8 no device
        dev_here = 1'b0;
        lat = 2;
        fill(1, -1);
        run(1'b0);
        chk(err_code == 2'd1, "R2 no device code", 64'(err_code), 64'd1);
        chk(mac_addr == FB, "R8 no device fallback", 64'(mac_addr), 64'(FB));
        chk_log(1);
        dev_here = 1'b1;

        // R6 good records across latencies and seeds; R4 crc varies
        for (int s = 0; s < 8; s++) begin
            logic [47:0] exp_mac;
            lat = s % 4;
            fill(s + 3, -1);
            crc_img = 8'(s * 29 + 1);
            exp_mac = {24'h00E0EE, rec_img[7], rec_img[6], rec_img[5]};
            run(s == 2);
            chk(err_code == 2'd0, "R6 good tag code", 64'(err_code), 64'd0);
            chk(mac_addr == exp_mac, "R6 address assembly", 64'(mac_addr), 64'(exp_mac));
            chk(crc_byte == crc_img, "R4 crc captured", 64'(crc_byte), 64'(crc_img));
            chk_log(34);
        end

        // R4 same record, different crc -> identical result
        fill(50, -1);
        crc_img = 8'h11;
        run(1'b0);
        begin
            logic [47:0] m1;
            m1 = mac_addr;
            crc_img = 8'hEE;
            run(1'b0);
            chk(mac_addr == m1 && err_code == 2'd0, "R4 crc no effect", 64'(mac_addr), 64'(m1));
        end

        // R6 bytes next to the tag window do not matter
        fill(60, -1);
        rec_img[10] = 8'h00;
        rec_img[27] = 8'hA5;
        run(1'b0);
        chk(err_code == 2'd0, "R6 neighbours ignored", 64'(err_code), 64'd0);

        // R7 every tag position corrupted
        for (int k = 0; k < 16; k++) begin
            lat = k % 3;
            fill(k + 70, k);
            run(1'b0);
            chk(err_code == 2'd2, "R7 bad tag code", 64'(err_code), 64'd2);
            chk(mac_addr == FB, "R7 bad tag fallback", 64'(mac_addr), 64'(FB));
        end

        // R10 hold while idle, and start-while-busy (run with poke) already logged 34 ops
        begin
            logic [47:0] m0;
            logic [1:0]  e0;
            logic [7:0]  c0;
            m0 = mac_addr; e0 = err_code; c0 = crc_byte;
            repeat (8) @(negedge clk);
            chk(mac_addr == m0 && err_code == e0 && crc_byte == c0, "R10 hold idle",
                64'(mac_addr), 64'(m0));
            chk(!eng_start && n_ops == 34, "R10 no activity idle", 64'(n_ops), 64'd34);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule